// File: doc/BRIEF.md
# Asynchronous Serial Transmitter Core

This core turns parallel characters into an asynchronous serial stream. A host writes a character into a holding register; as soon as the shift engine is free, the character moves into it and goes out on the line. Each frame is a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit and a high stop period. All bit timing comes from a 16x clock enable supplied from outside, so one bit lasts sixteen enables. The baud divisor that produces that enable is not part of this core.

Because the holding register and the shift engine are separate, the host can write the next character while the current one is still being sent. Two flags report progress. The holding-empty flag says when a new character can be written. The transmitter-empty flag says when the line has gone quiet after the last stop period. A break control pulls the line low. A loopback control sends the frame to an internal output for self-test and holds the external line at mark.

Top module: `sertx_core`

## Requirements
- R1: Every start, data, parity and full stop bit lasts exactly 16 cycles on which `tick16` is high. The serial output never changes during a frame on a cycle where `tick16` is low.
- R2: `cfg_len` selects the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data goes out least significant bit first. Bits of `wr_data` above the selected length are not sent.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_even` = 1 it makes the number of ones in data plus parity even; with `cfg_par_even` = 0 it makes that number odd. When `cfg_par_en` is 0, the stop period follows the data directly.
- R4: The stop period is high. With `cfg_stop2` = 0 it lasts 16 enables. With `cfg_stop2` = 1 it lasts 24 enables for 5-bit characters and 32 enables for all longer characters.
- R5: The line idles high, and every frame begins with one low start bit.
- R6: While `cfg_break` is 1, both `txd` and `loop_txd` are low, whatever the engine is doing. Releasing it lets the line return to its normal value.
- R7: A write (`wr_en` = 1) clears `hold_empty` on the next cycle. If the shift engine is idle, the character moves to it one cycle later, and `hold_empty` then sets again.
- R8: `tx_empty` is 1 only when the holding register is empty and the shift engine is idle. It rises on the cycle after the last stop enable of the final character.
- R9: A character written while another is being sent is kept in the holding register. It is sent immediately after the current frame ends, and `tx_empty` stays low in between.
- R10: While `cfg_loop` is 1, `txd` stays high and the whole frame appears on `loop_txd` instead.
- R11: After synchronous reset, `txd` and `loop_txd` are high and both `hold_empty` and `tx_empty` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | 16x bit-rate enable |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| cfg_len | input | 2 | Character length code (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Parity sense: 1 for even, 0 for odd |
| cfg_stop2 | input | 1 | Long stop period (1.5 or 2 bits) |
| cfg_break | input | 1 | Force the line low |
| cfg_loop | input | 1 | Loopback: mark `txd`, send the frame on `loop_txd` |
| txd | output | 1 | External serial output |
| loop_txd | output | 1 | Internal serial path for loopback |
| hold_empty | output | 1 | Holding register can accept a character |
| tx_empty | output | 1 | Holding register and shift engine both empty |

## Verification
The assertions check, on every cycle, the properties that hold at any moment. The line stays frozen during a frame when no enable arrives. A write empties neither flag. `tx_empty` never claims the transmitter is empty while a character is held. A break drives the internal path low. Loopback keeps `txd` at mark. The line sits at mark whenever the transmitter is empty. Only the bench's scenarios can show the frame content for each combination of length, parity and stop setting, the exact 24- and 32-enable stop periods, and a second character queued behind a busy engine.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int CHAR_W = 8;
    localparam int CNT_W  = 5;
    localparam int IDX_W  = $clog2(CHAR_W);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_even;
        logic       stop_long;
    } frame_cfg_t;

    function automatic logic [3:0] data_bits(input logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction

    function automatic logic [CNT_W-1:0] stop_last(input frame_cfg_t c);
        if (!c.stop_long)       return 5'd15;
        else if (c.len == 2'd0) return 5'd23;
        else                    return 5'd31;
    endfunction

    function automatic logic par_bit(input logic [CHAR_W-1:0] d, input frame_cfg_t c);
        logic [CHAR_W-1:0] m;
        m = d & (8'hFF >> (2'd3 - c.len));
        return c.par_even ? (^m) : ~(^m);
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic [W-1:0] hold_data,
    output logic         hold_full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else begin
            if (wr_en) begin
                hold_data <= wr_data;
                hold_full <= 1'b1;
            end else if (take) begin
                hold_full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              hold_full,
    input  logic [CHAR_W-1:0] din,
    input  frame_cfg_t        cfg,
    output logic              take,
    output logic              busy,
    output logic              line_raw
);
    phase_e            phase;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [CHAR_W-1:0] sh;
    logic              par_q;
    frame_cfg_t        cfg_q;
    logic [CNT_W-1:0]  last;
    logic              data_done;

    assign busy      = (phase != PH_IDLE);
    assign take      = !busy && hold_full;
    assign last      = (phase == PH_STOP) ? stop_last(cfg_q) : 5'd15;
    assign data_done = ({1'b0, idx} == data_bits(cfg_q.len) - 4'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            idx   <= '0;
            sh    <= '0;
            par_q <= 1'b0;
            cfg_q <= '0;
        end else if (phase == PH_IDLE) begin
            if (take) begin
                phase <= PH_START;
                cnt   <= '0;
                idx   <= '0;
                sh    <= din;
                par_q <= par_bit(din, cfg);
                cfg_q <= cfg;
            end
        end else if (tick16) begin
            if (cnt != last) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
                unique case (phase)
                    PH_START: phase <= PH_DATA;
                    PH_DATA: begin
                        if (data_done) begin
                            phase <= cfg_q.par_en ? PH_PAR : PH_STOP;
                        end else begin
                            idx <= idx + 1'b1;
                            sh  <= sh >> 1;
                        end
                    end
                    PH_PAR:  phase <= PH_STOP;
                    PH_STOP: phase <= PH_IDLE;
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        unique case (phase)
            PH_START: line_raw = 1'b0;
            PH_DATA:  line_raw = sh[0];
            PH_PAR:   line_raw = par_q;
            default:  line_raw = 1'b1;
        endcase
    end
endmodule

// File: rtl/sertx_line.sv
module sertx_line (
    input  logic raw,
    input  logic brk,
    input  logic loop,
    output logic txd,
    output logic loop_txd
);
    logic forced;

    assign forced   = brk ? 1'b0 : raw;
    assign loop_txd = forced;
    assign txd      = loop ? 1'b1 : forced;
endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_stop2,
    input  logic              cfg_break,
    input  logic              cfg_loop,
    output logic              txd,
    output logic              loop_txd,
    output logic              hold_empty,
    output logic              tx_empty
);
    logic [CHAR_W-1:0] hold_data;
    logic              hold_full;
    logic              take;
    logic              sh_busy;
    logic              line_raw;
    frame_cfg_t        cfg;

    assign cfg = '{len: cfg_len, par_en: cfg_par_en, par_even: cfg_par_even,
                   stop_long: cfg_stop2};

    sertx_hold #(.W(CHAR_W)) u_hold (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .take(take), .hold_data(hold_data), .hold_full(hold_full)
    );

    sertx_shift u_shift (
        .clk(clk), .rst(rst), .tick16(tick16), .hold_full(hold_full),
        .din(hold_data), .cfg(cfg), .take(take), .busy(sh_busy),
        .line_raw(line_raw)
    );

    sertx_line u_line (
        .raw(line_raw), .brk(cfg_break), .loop(cfg_loop),
        .txd(txd), .loop_txd(loop_txd)
    );

    assign hold_empty = !hold_full;
    assign tx_empty   = !hold_full && !sh_busy;
endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk (
    input logic clk,
    input logic rst,
    input logic tick16,
    input logic wr_en,
    input logic cfg_break,
    input logic cfg_loop,
    input logic txd,
    input logic loop_txd,
    input logic hold_empty,
    input logic tx_empty,
    input logic line_raw,
    input logic busy
);
    a_r1_no_tick_freeze: assert property (@(posedge clk) disable iff (rst)
        busy && !tick16 |=> $stable(line_raw));

    a_r7_write_clears: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !hold_empty);

    a_r7_idle_takes: assert property (@(posedge clk) disable iff (rst)
        !hold_empty && !busy && !wr_en |=> hold_empty);

    a_r8_empty_needs_hold: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> hold_empty && !busy);

    a_r6_break_low: assert property (@(posedge clk) disable iff (rst)
        cfg_break |-> !loop_txd);

    a_r10_loop_marks: assert property (@(posedge clk) disable iff (rst)
        cfg_loop |-> txd);

    a_r5_idle_mark: assert property (@(posedge clk) disable iff (rst)
        tx_empty && !cfg_break && !cfg_loop |-> txd);
endmodule

bind sertx_core sertx_core_chk u_chk (
    .clk(clk), .rst(rst), .tick16(tick16), .wr_en(wr_en),
    .cfg_break(cfg_break), .cfg_loop(cfg_loop), .txd(txd),
    .loop_txd(loop_txd), .hold_empty(hold_empty), .tx_empty(tx_empty),
    .line_raw(line_raw), .busy(sh_busy)
);

// File: tb/sertx_core_test.sv
module sertx_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       cfg_break = 1'b0;
    logic       cfg_loop = 1'b0;
    logic       txd, loop_txd, hold_empty, tx_empty;

    int checks = 0;
    int errors = 0;
    int tper = 1;
    int tcnt = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    sertx_core uut (
        .clk(clk), .rst(rst), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_stop2(cfg_stop2), .cfg_break(cfg_break), .cfg_loop(cfg_loop),
        .txd(txd), .loop_txd(loop_txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    always @(negedge clk) begin
        if (tcnt >= tper - 1) begin
            tcnt = 0;
            tick16 = 1'b1;
        end else begin
            tcnt = tcnt + 1;
            tick16 = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired: actual %0d cycles expected fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic write_char(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk(hold_empty == 1'b0, "R7 hold_empty after write", hold_empty, 0);
    endtask

    task automatic wait_idle();
        while (!tx_empty) @(negedge clk);
        @(negedge clk);
    endtask

    // Watches txd (or loop_txd) for one frame and compares it with the frame
    // computed from the configuration inputs.
    task automatic capture(input bit use_loop, input logic [7:0] d,
                           input bit chk_end, input bit expect_empty);
        int n, p, s, nb, per, last_idx, w, ones, stop_end;
        logic [9:0] exp_f, got_f;
        logic ln;
        bit stop_ok, mark_ok;
        n = 5 + int'(cfg_len);
        p = cfg_par_en ? 1 : 0;
        s = !cfg_stop2 ? 16 : ((cfg_len == 2'd0) ? 24 : 32);
        nb = 1 + n + p;
        per = tper;
        exp_f = '0;
        got_f = '0;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            exp_f[1+i] = d[i];
            ones = ones + int'(d[i]);
        end
        if (p == 1) exp_f[1+n] = cfg_par_even ? ones[0] : !ones[0];
        w = 0;
        while ((use_loop ? loop_txd : txd) != 1'b0 && w < 400 * per) begin
            @(negedge clk);
            w = w + 1;
        end
        chk(w < 400 * per, "R5 start bit seen", w, 0);
        stop_end = (nb * 16 + s) * per - per;
        last_idx = chk_end ? (nb * 16 + s) : stop_end - 1;
        stop_ok = 1'b1;
        mark_ok = 1'b1;
        for (int idx = 0; idx <= last_idx; idx++) begin
            if (idx > 0) @(negedge clk);
            ln = use_loop ? loop_txd : txd;
            if (use_loop && txd !== 1'b1) mark_ok = 1'b0;
            if (idx < nb * 16 * per) begin
                if (idx % (16 * per) == 8 * per) got_f[idx / (16 * per)] = ln;
            end else if (idx < stop_end) begin
                if (ln !== 1'b1) stop_ok = 1'b0;
            end
            if (chk_end && idx == 0) begin
                chk(hold_empty == 1'b1 && tx_empty == 1'b0, "R7 moved to shifter",
                    {hold_empty, tx_empty}, 2'b10);
            end
            if (chk_end && idx == last_idx - 1) begin
                chk(tx_empty == 1'b0 && ln == 1'b1, "R4 last stop cycle",
                    {tx_empty, ln}, 2'b01);
            end
            if (chk_end && idx == last_idx) begin
                chk(tx_empty == expect_empty, "R8 R4 tx_empty after stop",
                    tx_empty, expect_empty);
            end
        end
        chk(got_f == exp_f, "R2 R3 frame bits", got_f, exp_f);
        chk(stop_ok, "R4 stop period high", stop_ok, 1);
        if (use_loop) chk(mark_ok, "R10 txd held at mark", mark_ok, 1);
    endtask

    initial begin
        logic [7:0] d;
        bit brk_ok;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(txd == 1'b1 && loop_txd == 1'b1, "R11 line after reset", {txd, loop_txd}, 2'b11);
        chk(hold_empty == 1'b1 && tx_empty == 1'b1, "R11 flags after reset",
            {hold_empty, tx_empty}, 2'b11);

        // R2 R3 R4 sweep over every length, parity mode and stop setting
        for (int len = 0; len < 4; len++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int st = 0; st < 2; st++) begin
                    cfg_len = len[1:0];
                    cfg_par_en = (pm != 0);
                    cfg_par_even = (pm == 2);
                    cfg_stop2 = st[0];
                    for (int k = 0; k < 3; k++) begin
                        d = 8'h96 ^ (8'(k) * 8'h4F) ^ 8'(len * 16 + pm * 4 + st);
                        write_char(d);
                        capture(1'b0, d, 1'b1, 1'b1);
                        wait_idle();
                    end
                end
            end
        end

        // R1 sparse enable: one tick every third cycle
        tper = 3;
        cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_even = 1'b1; cfg_stop2 = 1'b0;
        write_char(8'hC5);
        capture(1'b0, 8'hC5, 1'b0, 1'b1);
        wait_idle();
        cfg_len = 2'd0; cfg_stop2 = 1'b1; cfg_par_en = 1'b0;
        write_char(8'h1B);
        capture(1'b0, 8'h1B, 1'b0, 1'b1);
        wait_idle();
        tper = 1;
        repeat (4) @(negedge clk);

        // R9 second character written during the first frame
        cfg_len = 2'd2; cfg_par_en = 1'b1; cfg_par_even = 1'b0; cfg_stop2 = 1'b1;
        write_char(8'h5D);
        fork
            capture(1'b0, 8'h5D, 1'b1, 1'b0);
            begin
                repeat (40) @(negedge clk);
                wr_en = 1'b1;
                wr_data = 8'h72;
                @(negedge clk);
                wr_en = 1'b0;
                chk(hold_empty == 1'b0, "R9 held while busy", hold_empty, 0);
                repeat (20) @(negedge clk);
                chk(hold_empty == 1'b0 && tx_empty == 1'b0, "R9 still held",
                    {hold_empty, tx_empty}, 2'b00);
            end
        join
        capture(1'b0, 8'h72, 1'b1, 1'b1);
        wait_idle();

        // R6 break while idle
        @(negedge clk);
        cfg_break = 1'b1;
        @(negedge clk);
        chk(txd == 1'b0 && loop_txd == 1'b0, "R6 break idle", {txd, loop_txd}, 2'b00);
        cfg_break = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R6 break released", txd, 1);

        // R6 break during a frame of all ones
        cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
        write_char(8'hFF);
        cfg_break = 1'b1;
        brk_ok = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (txd !== 1'b0) brk_ok = 1'b0;
        end
        chk(brk_ok, "R6 break over frame", brk_ok, 1);
        cfg_break = 1'b0;
        wait_idle();
        chk(txd == 1'b1, "R5 idle high after break", txd, 1);

        // R10 loopback
        cfg_loop = 1'b1;
        cfg_len = 2'd1; cfg_par_en = 1'b1; cfg_par_even = 1'b1; cfg_stop2 = 1'b1;
        write_char(8'h6B);
        capture(1'b1, 8'h6B, 1'b1, 1'b1);
        wait_idle();
        cfg_loop = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R10 loop released", txd, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule